// File: doc/BRIEF.md
# Dual-Chip NOR Flash Operation Sequencer

This block drives a 32-bit memory-mapped flash bus built from two 16-bit NOR chips placed side by side. The bus word's lower half reaches one chip and its upper half reaches the other. A client hands over one operation at a time: word program, block erase, block lock or block unlock. Each request carries a target address and, for program, a 32-bit data word. The sequencer then issues the write and read cycles that the operation needs. It polls the combined status word until both chips report ready or the retry budget for that operation runs out. It returns a two-bit result together with a one-cycle done pulse.

Command codes are 16 bits wide and are copied into both halves of the bus word, so the two chips always see the same command in the same cycle. Every bus access of an operation goes to the request address. Each bus cycle is a request that the sequencer holds until the bus acknowledges it for one cycle, so any wait time of the flash is hidden behind that handshake. An erase acts on one 256 KB block.

The controller is an eleven-state machine. IDLE accepts a request and moves to CLR. CLR writes clear-status. SETUP writes the operation's first command. CONFIRM writes the second command, or the data word for program. POLL_CMD writes read-status and POLL_RD reads the status word. POLL_RD goes back to POLL_CMD when the chips are not ready and budget remains. It goes to CHK_CMD when program is ready, and to RD_ARR on any other ready or on timeout. CHK_CMD and CHK_RD perform program's full status read. CHK_RD goes to ERR_CLR on a fault and to RD_ARR otherwise. ERR_CLR writes clear-status and goes to RD_ARR. RD_ARR writes read-array and goes to DONE. DONE pulses done and returns to IDLE. Every state other than IDLE moves on only when bus_ack arrives, except DONE.

Top module: `nor2x_op_seq`

## Requirements
- R1: Every command write places the 16-bit code in both halves of the bus word. For example, read-status 0x0070 goes out as 0x00700070. Only program's data write is sent unmodified.
- R2: Every operation begins with a clear-status write (0x50) and ends with a read-array write (0xFF), whatever the result. Every access of the operation uses the request address.
- R3: req_op is encoded as 00 = word program. Program writes 0x40 and then the request data word, then polls. After a ready poll it makes one more read-status write and status read, the full status check.
- R4: req_op 01 = block erase writes 0x20 then 0xD0. Op 10 = lock writes 0x60 then 0x01. Op 11 = unlock writes 0x60 then 0xD0. Polling follows in each case.
- R5: One poll is a 0x70 write followed by a bus read. Polling ends in success only when bit 7 (lower chip) and bit 23 (upper chip) are both set in the same read.
- R6: The poll budget is PROG_RETRIES for program, ERASE_RETRIES for erase and LOCK_RETRIES for lock and unlock. If that many polls pass without ready, the result is 01 (busy), with no full status check.
- R7: In program's full status check, a set bit 4 or bit 1 in either half (bits 4, 1, 20, 17) causes a clear-status write (0x50) before read-array. The result is then 10 (permission error).
- R8: Completion raises done for exactly one cycle, with result valid in that cycle: 00 = ok, 01 = busy, 10 = permission error.
- R9: busy is high from the cycle after acceptance through the done cycle. A request presented while busy is ignored: it changes neither the bus sequence nor the result.
- R10: bus_req, bus_we, bus_addr and bus_wdata hold steady until bus_ack is seen, for any acknowledge latency.
- R11: After reset the block is idle, with busy, done and bus_req all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Operation request, sampled only while idle |
| req_op | input | 2 | Operation: 00 program, 01 erase, 10 lock, 11 unlock |
| req_addr | input | ADDR_W | Target word/block address |
| req_data | input | 32 | Data word for program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 00 ok, 01 busy timeout, 10 permission error |
| bus_req | output | 1 | Bus cycle request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | 32 | Bus write data |
| bus_rdata | input | 32 | Bus read data, valid with bus_ack on a read |
| bus_ack | input | 1 | One-cycle acknowledge that completes the current bus cycle |

## Verification
The embedded properties watch the cycle-level rules on every clock: command words carry the same code in both halves, bus outputs stay frozen until acknowledged, done lasts one cycle with a legal code, the final write before done is read-array, a permission error only ever ends a program, the latched operation cannot change mid-run, and the retry count never passes its budget. Several behaviours only show in whole scenarios, because each depends on the order of many transfers: the exact command order of each operation, the way the ready bit is combined across both chips, the timeout count, and the error path with its extra clear-status. The bench sweeps every operation against per-chip ready delays on both sides of the budget, against fault bits in either chip and against several acknowledge latencies. For each case it compares the logged transfers and the result with a sequence it builds itself.

// File: rtl/nor2x_pkg.sv
package nor2x_pkg;

    typedef enum logic [1:0] {
        OP_PROG   = 2'b00,
        OP_ERASE  = 2'b01,
        OP_LOCK   = 2'b10,
        OP_UNLOCK = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        RES_OK   = 2'b00,
        RES_BUSY = 2'b01,
        RES_PERM = 2'b10
    } res_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CLR,
        S_SETUP,
        S_CONFIRM,
        S_POLL_CMD,
        S_POLL_RD,
        S_CHK_CMD,
        S_CHK_RD,
        S_ERR_CLR,
        S_RD_ARR,
        S_DONE
    } state_e;

    localparam int unsigned LANE_W = 16;

    localparam logic [LANE_W-1:0] CODE_STATUS   = 16'h0070;
    localparam logic [LANE_W-1:0] CODE_CLEAR    = 16'h0050;
    localparam logic [LANE_W-1:0] CODE_PROGRAM  = 16'h0040;
    localparam logic [LANE_W-1:0] CODE_ERASE    = 16'h0020;
    localparam logic [LANE_W-1:0] CODE_ERASE_GO = 16'h00D0;
    localparam logic [LANE_W-1:0] CODE_PROTECT  = 16'h0060;
    localparam logic [LANE_W-1:0] CODE_LOCK_GO  = 16'h0001;
    localparam logic [LANE_W-1:0] CODE_FREE_GO  = 16'h00D0;
    localparam logic [LANE_W-1:0] CODE_ARRAY    = 16'h00FF;

    localparam int unsigned BIT_READY  = 7;
    localparam int unsigned BIT_PGMERR = 4;
    localparam int unsigned BIT_LOCKED = 1;

endpackage

// File: rtl/nor2x_lane_rep.sv
module nor2x_lane_rep
    import nor2x_pkg::*;
#(
    parameter int unsigned CHIPS = 2
) (
    input  logic [LANE_W-1:0]       code,
    output logic [CHIPS*LANE_W-1:0] word
);

    for (genvar g = 0; g < CHIPS; g++) begin : g_lane
        assign word[g*LANE_W +: LANE_W] = code;
    end

endmodule

// File: rtl/nor2x_status_eval.sv
module nor2x_status_eval
    import nor2x_pkg::*;
#(
    parameter int unsigned CHIPS = 2
) (
    input  logic [CHIPS*LANE_W-1:0] word,
    output logic                    all_ready,
    output logic                    any_fault
);

    logic [CHIPS-1:0] lane_rdy;
    logic [CHIPS-1:0] lane_flt;

    for (genvar g = 0; g < CHIPS; g++) begin : g_lane
        assign lane_rdy[g] = word[g*LANE_W + BIT_READY];
        assign lane_flt[g] = word[g*LANE_W + BIT_PGMERR] | word[g*LANE_W + BIT_LOCKED];
    end

    assign all_ready = &lane_rdy;
    assign any_fault = |lane_flt;

endmodule

// File: rtl/nor2x_retry_ctr.sv
module nor2x_retry_ctr #(
    parameter int unsigned CNT_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             incr,
    input  logic [CNT_W-1:0] limit,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (incr) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = (cnt_q == limit - 1'b1);

    // R6
    ctr_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
        incr |-> (cnt_q < limit - 1'b1));

endmodule

// File: rtl/nor2x_op_seq.sv
module nor2x_op_seq
    import nor2x_pkg::*;
#(
    parameter int unsigned ADDR_W        = 24,
    parameter int unsigned CNT_W         = 22,
    parameter int unsigned PROG_RETRIES  = 1000,
    parameter int unsigned ERASE_RETRIES = 3000000,
    parameter int unsigned LOCK_RETRIES  = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_data,
    output logic              busy,
    output logic              done,
    output logic [1:0]        result,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [31:0]       bus_wdata,
    input  logic [31:0]       bus_rdata,
    input  logic              bus_ack
);

    localparam int unsigned CHIPS  = 2;
    localparam int unsigned DATA_W = CHIPS * LANE_W;
    localparam logic [CNT_W-1:0] LIM_PROG  = CNT_W'(PROG_RETRIES);
    localparam logic [CNT_W-1:0] LIM_ERASE = CNT_W'(ERASE_RETRIES);
    localparam logic [CNT_W-1:0] LIM_LOCK  = CNT_W'(LOCK_RETRIES);

    state_e            state_q, state_d;
    op_e               op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    res_e              res_q;

    logic [LANE_W-1:0] code;
    logic [DATA_W-1:0] rep_word;
    logic              all_ready, any_fault;
    logic              ctr_clear, ctr_incr, ctr_last;
    logic [CNT_W-1:0]  limit;
    logic              data_phase;

    nor2x_lane_rep #(.CHIPS(CHIPS)) u_rep (
        .code (code),
        .word (rep_word)
    );

    nor2x_status_eval #(.CHIPS(CHIPS)) u_stat (
        .word      (bus_rdata),
        .all_ready (all_ready),
        .any_fault (any_fault)
    );

    always_comb begin
        unique case (op_q)
            OP_PROG:  limit = LIM_PROG;
            OP_ERASE: limit = LIM_ERASE;
            default:  limit = LIM_LOCK;
        endcase
    end

    assign ctr_clear = (state_q == S_CONFIRM) && bus_ack;
    assign ctr_incr  = (state_q == S_POLL_RD) && bus_ack && !all_ready && !ctr_last;

    nor2x_retry_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (ctr_clear),
        .incr  (ctr_incr),
        .limit (limit),
        .last  (ctr_last)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (req_valid) state_d = S_CLR;
            S_CLR:      if (bus_ack) state_d = S_SETUP;
            S_SETUP:    if (bus_ack) state_d = S_CONFIRM;
            S_CONFIRM:  if (bus_ack) state_d = S_POLL_CMD;
            S_POLL_CMD: if (bus_ack) state_d = S_POLL_RD;
            S_POLL_RD: begin
                if (bus_ack) begin
                    if (all_ready)
                        state_d = (op_q == OP_PROG) ? S_CHK_CMD : S_RD_ARR;
                    else if (ctr_last)
                        state_d = S_RD_ARR;
                    else
                        state_d = S_POLL_CMD;
                end
            end
            S_CHK_CMD:  if (bus_ack) state_d = S_CHK_RD;
            S_CHK_RD:   if (bus_ack) state_d = any_fault ? S_ERR_CLR : S_RD_ARR;
            S_ERR_CLR:  if (bus_ack) state_d = S_RD_ARR;
            S_RD_ARR:   if (bus_ack) state_d = S_DONE;
            S_DONE:     state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // State and context registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            op_q    <= OP_PROG;
            addr_q  <= '0;
            data_q  <= '0;
            res_q   <= RES_OK;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && req_valid) begin
                op_q   <= op_e'(req_op);
                addr_q <= req_addr;
                data_q <= req_data;
                res_q  <= RES_OK;
            end
            if (state_q == S_POLL_RD && bus_ack && !all_ready && ctr_last)
                res_q <= RES_BUSY;
            if (state_q == S_CHK_RD && bus_ack && any_fault)
                res_q <= RES_PERM;
        end
    end

    // Outputs
    always_comb begin
        bus_req    = 1'b0;
        bus_we     = 1'b1;
        code       = CODE_ARRAY;
        data_phase = 1'b0;
        unique case (state_q)
            S_IDLE, S_DONE: begin
                bus_req = 1'b0;
            end
            S_CLR, S_ERR_CLR: begin
                bus_req = 1'b1;
                code    = CODE_CLEAR;
            end
            S_SETUP: begin
                bus_req = 1'b1;
                unique case (op_q)
                    OP_PROG:  code = CODE_PROGRAM;
                    OP_ERASE: code = CODE_ERASE;
                    default:  code = CODE_PROTECT;
                endcase
            end
            S_CONFIRM: begin
                bus_req = 1'b1;
                unique case (op_q)
                    OP_PROG:   data_phase = 1'b1;
                    OP_ERASE:  code = CODE_ERASE_GO;
                    OP_LOCK:   code = CODE_LOCK_GO;
                    OP_UNLOCK: code = CODE_FREE_GO;
                    default:   code = CODE_FREE_GO;
                endcase
            end
            S_POLL_CMD, S_CHK_CMD: begin
                bus_req = 1'b1;
                code    = CODE_STATUS;
            end
            S_POLL_RD, S_CHK_RD: begin
                bus_req = 1'b1;
                bus_we  = 1'b0;
            end
            S_RD_ARR: begin
                bus_req = 1'b1;
                code    = CODE_ARRAY;
            end
            default: bus_req = 1'b0;
        endcase
    end

    assign bus_addr  = addr_q;
    assign bus_wdata = data_phase ? data_q : (bus_we ? rep_word : '0);
    assign busy      = (state_q != S_IDLE);
    assign done      = (state_q == S_DONE);
    assign result    = res_q;

    // R1
    cmd_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && !(state_q == S_CONFIRM && op_q == OP_PROG))
            |-> (bus_wdata[31:16] == bus_wdata[15:0]));

    // R10
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) && $stable(bus_addr)
                                   && $stable(bus_wdata)));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    result_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result != 2'b11));

    // R2
    last_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(bus_req && bus_ack && bus_we && bus_wdata == {CHIPS{CODE_ARRAY}}));

    // R9
    op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(op_q) && $stable(addr_q)));

    // R7
    perm_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == RES_PERM) |-> (op_q == OP_PROG));

endmodule

// File: tb/sim_nor2x_op_seq.sv
`timescale 1ns/1ps
module sim_nor2x_op_seq;

    localparam int AW     = 24;
    localparam int L_PROG = 4;
    localparam int L_ERAS = 6;
    localparam int L_LOCK = 3;
    localparam int NEVER  = 1000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = 2'b00;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_data = '0;
    logic          busy, done;
    logic [1:0]    result;
    logic          bus_req, bus_we;
    logic [AW-1:0] bus_addr;
    logic [31:0]   bus_wdata;
    logic [31:0]   bus_rdata = '0;
    logic          bus_ack = 1'b0;

    always #10 clk = ~clk;

    nor2x_op_seq #(
        .ADDR_W(AW), .CNT_W(22),
        .PROG_RETRIES(L_PROG), .ERASE_RETRIES(L_ERAS), .LOCK_RETRIES(L_LOCK)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .busy(busy), .done(done),
        .result(result), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // flash / bus model configuration
    int m_lat = 0, m_lo = 1, m_hi = 1, m_err = 0;
    int rd_idx = 0, wait_c = 0;
    int log_n = 0;
    logic          log_we [0:63];
    logic [31:0]   log_d  [0:63];
    logic [AW-1:0] log_a  [0:63];
    int done_cnt = 0;
    logic [1:0] res_cap = 2'b00;

    logic          exp_we [0:63];
    logic [31:0]   exp_d  [0:63];
    int exp_n = 0;

    function automatic logic [31:0] rep(input logic [15:0] c);
        return {c, c};
    endfunction

    function automatic logic [31:0] status_word(input int idx);
        logic [31:0] w;
        w = '0;
        w[7]  = (idx >= m_lo);
        w[23] = (idx >= m_hi);
        w[4]  = (m_err == 1);
        w[17] = (m_err == 2);
        return w;
    endfunction

    always @(negedge clk) begin
        if (done) begin
            done_cnt = done_cnt + 1;
            res_cap  = result;
        end
        if (bus_ack) begin
            bus_ack = 1'b0;
        end else if (bus_req) begin
            if (wait_c >= m_lat) begin
                wait_c = 0;
                bus_ack = 1'b1;
                if (log_n < 64) begin
                    log_we[log_n] = bus_we;
                    log_d[log_n]  = bus_we ? bus_wdata : 32'h0;
                    log_a[log_n]  = bus_addr;
                end
                log_n = log_n + 1;
                if (!bus_we) begin
                    rd_idx    = rd_idx + 1;
                    bus_rdata = status_word(rd_idx);
                end
            end else begin
                wait_c = wait_c + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic we, input logic [31:0] d);
        exp_we[exp_n] = we;
        exp_d[exp_n]  = d;
        exp_n++;
    endtask

    task automatic run_case(input int op, input int lo, input int hi,
                            input int lat, input int err, input int idx);
        logic [AW-1:0] a;
        logic [31:0]   d;
        int lim, peak, np, t;
        logic [1:0] eres;
        a = AW'(24'h040000 * (op + 1) + idx);
        d = 32'hA5C3_0000 ^ 32'(idx * 7);
        @(negedge clk);
        m_lat = lat; m_lo = lo; m_hi = hi; m_err = err;
        rd_idx = 0; wait_c = 0; log_n = 0; done_cnt = 0;
        exp_n = 0;
        // expected sequence, R2..R7
        push(1'b1, rep(16'h0050));
        case (op)
            0: begin push(1'b1, rep(16'h0040)); push(1'b1, d); end
            1: begin push(1'b1, rep(16'h0020)); push(1'b1, rep(16'h00D0)); end
            2: begin push(1'b1, rep(16'h0060)); push(1'b1, rep(16'h0001)); end
            default: begin push(1'b1, rep(16'h0060)); push(1'b1, rep(16'h00D0)); end
        endcase
        lim  = (op == 0) ? L_PROG : (op == 1) ? L_ERAS : L_LOCK;
        peak = (lo > hi) ? lo : hi;
        np   = (peak <= lim) ? peak : lim;
        for (int i = 0; i < np; i++) begin
            push(1'b1, rep(16'h0070));
            push(1'b0, 32'h0);
        end
        if (peak > lim) eres = 2'b01;
        else if (op == 0) begin
            push(1'b1, rep(16'h0070));
            push(1'b0, 32'h0);
            if (err != 0) begin push(1'b1, rep(16'h0050)); eres = 2'b10; end
            else eres = 2'b00;
        end else eres = 2'b00;
        push(1'b1, rep(16'h00FF));

        req_valid = 1'b1; req_op = 2'(op); req_addr = a; req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy === 1'b1, "R9", "busy after accept", 32'(busy), 32'd1);
        @(negedge clk);
        // R9: a request while busy must be ignored
        req_valid = 1'b1; req_op = 2'(op ^ 1); req_addr = ~a; req_data = ~d;
        @(negedge clk);
        req_valid = 1'b0;
        t = 0;
        while (done_cnt == 0 && t < 3000) begin @(negedge clk); t++; end
        repeat (3) @(negedge clk);
        check(done_cnt == 1, "R8", "done pulses", 32'(done_cnt), 32'd1);
        check(res_cap == eres, (eres == 2'b01) ? "R6" : (eres == 2'b10) ? "R7" : "R5",
              "result", 32'(res_cap), 32'(eres));
        check(log_n == exp_n, "R3", "transfer count", 32'(log_n), 32'(exp_n));
        for (int i = 0; i < exp_n && i < log_n && i < 64; i++) begin
            check(log_we[i] === exp_we[i] && log_d[i] === exp_d[i] && log_a[i] === a,
                  (i == 0 || i == exp_n - 1) ? "R2" : (i < 3) ? "R4" : "R1",
                  $sformatf("transfer %0d op %0d", i, op), log_d[i], exp_d[i]);
        end
        check(busy === 1'b0 && bus_req === 1'b0, "R9", "idle after done",
              {30'd0, busy, bus_req}, 32'd0);
    endtask

    initial begin
        int idx;
        int rv [0:3];
        idx = 0;
        repeat (3) @(negedge clk);
        // R11 reset state
        check(busy === 1'b0 && done === 1'b0 && bus_req === 1'b0, "R11", "reset outputs",
              {29'd0, busy, done, bus_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0 && bus_req === 1'b0, "R11", "idle after reset",
              {30'd0, busy, bus_req}, 32'd0);
        for (int op = 0; op < 4; op++) begin
            int lim;
            lim = (op == 0) ? L_PROG : (op == 1) ? L_ERAS : L_LOCK;
            rv[0] = 1; rv[1] = 2; rv[2] = lim; rv[3] = NEVER;
            for (int i = 0; i < 4; i++)
                for (int j = 0; j < 4; j++)
                    for (int lat = 0; lat < 3; lat++)
                        for (int err = 0; err < ((op == 0) ? 3 : 1); err++) begin
                            run_case(op, rv[i], rv[j], lat, err, idx);
                            idx++;
                        end
        end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

endmodule